// File: doc/BRIEF.md
# Set-Associative Cache Tag and Maintenance Controller

This block is the bookkeeping half of a small set-associative read cache. It keeps a valid bit for every line, a tag for every line and a round-robin victim pointer for every set. A lookup port takes a line address and reports hit or miss together with the matching way. A fill port records a new tag in the way chosen by the victim policy and reports that way, so that a separate data store can write the line. Line data storage and the path to backing memory belong to other blocks.

Software controls the block through a four-register bus: an enable register, a state register, a wipe register that drops every line at once, and a line-drop register that names one line by its {set, way} pair. The state bit trails the enable bit, so software turns the cache off, polls until the state reads 0, and only then drops single lines. A line-drop written while the cache is still active has no effect and raises a sticky error flag.

Top module: `cache_maint_ctrl`

## Requirements
- R1: After reset the enable bit, the state bit and the error flag read 0, every line is invalid, and every lookup misses.
- R2: Writing 1 to bit 0 of the enable register (address 0) sets the state bit one cycle later. A state read issued in the cycle right after the write returns 0, and a read one cycle after that returns 1.
- R3: Writing 0 to the enable bit clears the state bit one cycle later. If a lookup was accepted in the same cycle as that write, the state bit stays 1 for one more cycle, until that lookup has returned its result.
- R4: A lookup returns its result two clock edges after the request, with lk_done high for one cycle. It hits when some valid way of the set holds the tag. The set index is byte-address bits [8:4] (line-address bits just above the 16-byte offset) and the tag is every bit above the index. lk_way gives the lowest-numbered matching way.
- R5: While the enable bit or the state bit is 0, a lookup still completes but always misses, and a fill is ignored: no fill_done pulse, and no tag or valid bit changes.
- R6: A fill into a set with at least one invalid way writes the lowest-numbered invalid way, marks it valid, and leaves the victim pointer unchanged. fill_done and fill_way appear one edge after the request.
- R7: A fill into a set whose ways are all valid writes the way the victim pointer names, and the pointer then advances by one, modulo the way count.
- R8: Writing 1 to bit 0 of the wipe register (address 2) invalidates every line and resets every victim pointer to way 0 in one cycle, whatever the enable state. This register reads as 0.
- R9: A write to the line-drop register (address 3) while the state bit is 0 clears the valid bit of exactly one line: the way in bits [1:0] and the set in the bits above. It also points that set's victim pointer at the dropped way.
- R10: A line-drop write while the state bit is 1 changes no line and sets the error flag, which reads in bit 1 of the state register (address 1). The flag stays set until software writes 1 to bit 1 of the state register.
- R11: Reads return data one edge after the request. The enable register reads its enable bit in bit 0, the state register reads the state bit in bit 0 and the error flag in bit 1, and the two maintenance registers read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 enable, 1 state, 2 wipe, 3 line-drop |
| reg_wdata | input | IDX_W+WAY_W | Write data |
| reg_rdata | output | IDX_W+WAY_W | Registered read data |
| lk_req | input | 1 | Lookup request |
| lk_line | input | ADDR_W-OFF_W | Line address to look up |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | WAY_W | Way that hit |
| fill_req | input | 1 | Fill request |
| fill_line | input | ADDR_W-OFF_W | Line address to record |
| fill_done | output | 1 | Fill accepted |
| fill_way | output | WAY_W | Way written by the fill |

## Verification
The bench builds the block with a 256-byte cache, 16-byte lines, 4 ways and 12-bit addresses, which gives 4 sets and 6-bit tags. At that size it can fill every set past capacity, so both the lowest-invalid choice and the rotation of the victim pointer are reached, and every stored tag can be looked up against a model computed arithmetically in the bench. The small geometry also lets the bench look up every set after a wipe, drop lines at the first and last way, and time the state bit against the enable bit both with and without a lookup in flight.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  typedef enum logic [1:0] {
    RG_ENABLE = 2'd0,
    RG_STATE  = 2'd1,
    RG_WIPE   = 2'd2,
    RG_DROP   = 2'd3
  } cmc_reg_e;
endpackage

// File: rtl/cmc_regs.sv
module cmc_regs
  import cmc_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int WAY_W = 2,
  localparam int RW = IDX_W + WAY_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic             reg_re,
  input  logic [1:0]       reg_addr,
  input  logic [RW-1:0]    reg_wdata,
  input  logic             lk_busy,
  output logic [RW-1:0]    reg_rdata,
  output logic             en_q,
  output logic             active,
  output logic             wipe_go,
  output logic             drop_go,
  output logic [IDX_W-1:0] drop_idx,
  output logic [WAY_W-1:0] drop_way
);
  logic err_q;
  cmc_reg_e sel;

  assign sel      = cmc_reg_e'(reg_addr);
  assign wipe_go  = reg_we && (sel == RG_WIPE) && reg_wdata[0];
  assign drop_go  = reg_we && (sel == RG_DROP) && !active;
  assign drop_idx = reg_wdata[RW-1:WAY_W];
  assign drop_way = reg_wdata[WAY_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      active    <= 1'b0;
      err_q     <= 1'b0;
      reg_rdata <= '0;
    end else begin
      // state trails enable; an accepted lookup holds it for one more cycle
      active <= en_q | lk_busy;
      if (reg_we) begin
        case (sel)
          RG_ENABLE: en_q <= reg_wdata[0];
          RG_STATE:  if (reg_wdata[1]) err_q <= 1'b0;
          RG_DROP:   if (active) err_q <= 1'b1;
          default:   ;
        endcase
      end
      if (reg_re) begin
        case (sel)
          RG_ENABLE: reg_rdata <= {{(RW-1){1'b0}}, en_q};
          RG_STATE:  reg_rdata <= {{(RW-2){1'b0}}, err_q, active};
          default:   reg_rdata <= '0;
        endcase
      end
    end
  end

  p_state_follows_r2: assert property (@(posedge clk) disable iff (rst)
    en_q |=> active);

  p_drop_blocked_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_we && sel == RG_DROP && active) |=> err_q);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (err_q && !(reg_we && sel == RG_STATE && reg_wdata[1])) |=> err_q);
endmodule

// File: rtl/cmc_way_ram.sv
module cmc_way_ram #(
  parameter int DEPTH = 32,
  parameter int DW    = 23,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cmc_set_state.sv
module cmc_set_state #(
  parameter int SETS  = 32,
  parameter int WAYS  = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wipe_go,
  input  logic             drop_go,
  input  logic [IDX_W-1:0] drop_idx,
  input  logic [WAY_W-1:0] drop_way,
  input  logic             fill_go,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [WAY_W-1:0] fill_way,
  output logic [WAYS-1:0]  rd_valid
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAY_W-1:0] ptr_q   [SETS];
  logic [WAYS-1:0]  vset;
  logic             found;

  assign rd_valid = valid_q[rd_idx];
  assign vset     = valid_q[fill_idx];

  always_comb begin
    fill_way = ptr_q[fill_idx];
    found    = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !vset[w]) begin
        fill_way = WAY_W'(w);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || wipe_go) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        ptr_q[s]   <= '0;
      end
    end else begin
      if (drop_go) begin
        valid_q[drop_idx][drop_way] <= 1'b0;
        ptr_q[drop_idx]             <= drop_way;
      end
      if (fill_go) begin
        valid_q[fill_idx][fill_way] <= 1'b1;
        if (!found) ptr_q[fill_idx] <= fill_way + WAY_W'(1);
      end
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_chk
    p_wipe_clears_r8: assert property (@(posedge clk) disable iff (rst)
      wipe_go |=> (valid_q[s] == '0 && ptr_q[s] == '0));
    p_fill_marks_r6: assert property (@(posedge clk) disable iff (rst)
      (fill_go && !wipe_go && fill_idx == IDX_W'(s)) |=> (valid_q[s] != '0));
    p_drop_points_r9: assert property (@(posedge clk) disable iff (rst)
      (drop_go && !wipe_go && drop_idx == IDX_W'(s)) |=> (ptr_q[s] == $past(drop_way)));
  end
endmodule

// File: rtl/cache_maint_ctrl.sv
module cache_maint_ctrl #(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 2048,
  parameter int LINE_BYTES  = 16,
  parameter int WAYS        = 4,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int SETS  = CACHE_BYTES / (LINE_BYTES * WAYS),
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
  localparam int RW    = IDX_W + WAY_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_we,
  input  logic                  reg_re,
  input  logic [1:0]            reg_addr,
  input  logic [RW-1:0]         reg_wdata,
  output logic [RW-1:0]         reg_rdata,
  input  logic                  lk_req,
  input  logic [ADDR_W-1:OFF_W] lk_line,
  output logic                  lk_done,
  output logic                  lk_hit,
  output logic [WAY_W-1:0]      lk_way,
  input  logic                  fill_req,
  input  logic [ADDR_W-1:OFF_W] fill_line,
  output logic                  fill_done,
  output logic [WAY_W-1:0]      fill_way
);
  logic             en_q, active, wipe_go, drop_go, go;
  logic [IDX_W-1:0] drop_idx, lk_idx, fill_idx;
  logic [WAY_W-1:0] drop_way, pick_way, hit_way;
  logic [TAG_W-1:0] lk_tag, fill_tag, s1_tag;
  logic [TAG_W-1:0] rd_tag [WAYS];
  logic [WAYS-1:0]  rd_valid, s1_valid, hit_vec;
  logic             lk_acc, fill_go, s1_req, s1_acc;

  assign lk_idx   = lk_line[OFF_W+IDX_W-1:OFF_W];
  assign lk_tag   = lk_line[ADDR_W-1:OFF_W+IDX_W];
  assign fill_idx = fill_line[OFF_W+IDX_W-1:OFF_W];
  assign fill_tag = fill_line[ADDR_W-1:OFF_W+IDX_W];
  assign go       = en_q & active;
  assign lk_acc   = lk_req & go;
  assign fill_go  = fill_req & go & ~wipe_go;

  cmc_regs #(.IDX_W(IDX_W), .WAY_W(WAY_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .lk_busy(s1_acc),
    .reg_rdata(reg_rdata), .en_q(en_q), .active(active),
    .wipe_go(wipe_go), .drop_go(drop_go), .drop_idx(drop_idx), .drop_way(drop_way)
  );

  cmc_set_state #(.SETS(SETS), .WAYS(WAYS)) u_state (
    .clk(clk), .rst(rst), .wipe_go(wipe_go), .drop_go(drop_go),
    .drop_idx(drop_idx), .drop_way(drop_way), .fill_go(fill_go),
    .fill_idx(fill_idx), .rd_idx(lk_idx), .fill_way(pick_way), .rd_valid(rd_valid)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    cmc_way_ram #(.DEPTH(SETS), .DW(TAG_W)) u_ram (
      .clk(clk), .we(fill_go && pick_way == WAY_W'(w)), .waddr(fill_idx),
      .wdata(fill_tag), .raddr(lk_idx), .rdata(rd_tag[w])
    );
    assign hit_vec[w] = s1_valid[w] && (rd_tag[w] == s1_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_req    <= 1'b0;
      s1_acc    <= 1'b0;
      s1_tag    <= '0;
      s1_valid  <= '0;
      lk_done   <= 1'b0;
      lk_hit    <= 1'b0;
      lk_way    <= '0;
      fill_done <= 1'b0;
      fill_way  <= '0;
    end else begin
      s1_req    <= lk_req;
      s1_acc    <= lk_acc;
      s1_tag    <= lk_tag;
      s1_valid  <= rd_valid;
      lk_done   <= s1_req;
      lk_hit    <= s1_acc && (hit_vec != '0);
      lk_way    <= hit_way;
      fill_done <= fill_go;
      fill_way  <= pick_way;
    end
  end

  p_state_drains_r3: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !s1_acc) |=> !active);

  p_fill_needs_on_r5: assert property (@(posedge clk) disable iff (rst)
    fill_done |-> $past(en_q && active));

  p_hit_needs_on_r5: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> $past(en_q && active, 2));

  p_result_timing_r4: assert property (@(posedge clk) disable iff (rst)
    s1_req |=> lk_done);
endmodule

// File: tb/cache_maint_ctrl_test.sv
module cache_maint_ctrl_test;
  localparam int NS = 4, NW = 4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 0, reg_re = 0;
  logic [1:0] reg_addr = 0;
  logic [3:0] reg_wdata = 0;
  logic [3:0] reg_rdata;
  logic lk_req = 0, fill_req = 0;
  logic [11:4] lk_line = 0, fill_line = 0;
  logic lk_done, lk_hit, fill_done;
  logic [1:0] lk_way, fill_way;

  int total = 0, bad = 0;
  bit mval [NS][NW];
  int mtag [NS][NW];
  int mptr [NS];
  bit m_on = 0;

  always #2 clk = ~clk;

  cache_maint_ctrl #(.ADDR_W(12), .CACHE_BYTES(256), .LINE_BYTES(16), .WAYS(4)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_req(lk_req), .lk_line(lk_line),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_way(lk_way), .fill_req(fill_req),
    .fill_line(fill_line), .fill_done(fill_done), .fill_way(fill_way)
  );

  task automatic chk(bit ok, string req, int act, int exp, string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic reg_wr(int a, int d);
    reg_we = 1; reg_addr = 2'(a); reg_wdata = 4'(d);
    tick();
    reg_we = 0;
  endtask

  task automatic reg_rd(int a, output int d);
    reg_re = 1; reg_addr = 2'(a);
    tick();
    d = int'(reg_rdata);
    reg_re = 0;
  endtask

  task automatic model_wipe();
    for (int s = 0; s < NS; s++) begin
      mptr[s] = 0;
      for (int w = 0; w < NW; w++) mval[s][w] = 0;
    end
  endtask

  task automatic look(int s, int t, string req);
    bit eh = 0; int ew = 0;
    for (int w = NW - 1; w >= 0; w--)
      if (m_on && mval[s][w] && mtag[s][w] == t) begin eh = 1; ew = w; end
    lk_req = 1; lk_line = {6'(t), 2'(s)};
    tick();
    lk_req = 0;
    chk(lk_done == 0, req, int'(lk_done), 0, "lk_done after one edge");
    tick();
    chk(lk_done == 1, req, int'(lk_done), 1, "lk_done after two edges");
    chk(lk_hit == eh, req, int'(lk_hit), int'(eh), $sformatf("hit set%0d tag%0d", s, t));
    if (eh) chk(int'(lk_way) == ew, req, int'(lk_way), ew, "hit way");
  endtask

  task automatic fill(int s, int t, string req);
    int ew = -1;
    if (m_on) begin
      for (int w = NW - 1; w >= 0; w--) if (!mval[s][w]) ew = w;
      if (ew < 0) begin ew = mptr[s]; mptr[s] = (mptr[s] + 1) % NW; end
      mval[s][ew] = 1; mtag[s][ew] = t;
    end
    fill_req = 1; fill_line = {6'(t), 2'(s)};
    tick();
    fill_req = 0;
    chk(fill_done == m_on, req, int'(fill_done), int'(m_on), "fill_done");
    if (m_on) chk(int'(fill_way) == ew, req, int'(fill_way), ew, $sformatf("fill way set%0d", s));
  endtask

  task automatic turn_on();
    int d;
    reg_wr(0, 1);
    reg_rd(1, d); chk(d[0] == 0, "R2", d[0], 0, "state in cycle after enable");
    reg_rd(1, d); chk(d[0] == 1, "R2", d[0], 1, "state two cycles after enable");
    m_on = 1;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog run incomplete actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int d;
    model_wipe();
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 / R11: reset state and read map
    reg_rd(0, d); chk(d == 0, "R1", d, 0, "enable reg after reset");
    reg_rd(1, d); chk(d == 0, "R1", d, 0, "state reg after reset");
    reg_rd(2, d); chk(d == 0, "R11", d, 0, "wipe reg reads zero");
    reg_rd(3, d); chk(d == 0, "R11", d, 0, "drop reg reads zero");
    look(1, 5, "R1");
    // R5: fill while disabled is ignored
    fill(0, 9, "R5");
    turn_on();
    reg_rd(0, d); chk(d == 1, "R11", d, 1, "enable reg reads enable bit");
    look(0, 9, "R5");
    // R6 / R7: fill every set past capacity
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < 6; k++) fill(s, s * 8 + k + 1, k < 4 ? "R6" : "R7");
    for (int s = 0; s < NS; s++) begin
      for (int k = 0; k < 6; k++) look(s, s * 8 + k + 1, "R4");
      look(s, 63, "R4");
    end
    // R10: drop while active is ignored and flagged
    reg_wr(3, (2 << 2) | 1);
    reg_rd(1, d); chk(d == 3, "R10", d, 3, "state with error flag");
    look(2, mtag[2][1], "R10");
    reg_wr(1, 2);
    reg_rd(1, d); chk(d == 1, "R10", d, 1, "error flag cleared");
    // R3: disable with a lookup in flight
    reg_we = 1; reg_addr = 2'd0; reg_wdata = 4'd0;
    lk_req = 1; lk_line = {6'(mtag[0][0]), 2'd0};
    tick();
    reg_we = 0; lk_req = 0;
    reg_rd(1, d); chk(d[0] == 1, "R3", d[0], 1, "state one cycle after disable");
    reg_rd(1, d); chk(d[0] == 1, "R3", d[0], 1, "state held by lookup in flight");
    reg_rd(1, d); chk(d[0] == 0, "R3", d[0], 0, "state after drain");
    m_on = 0;
    // R9: drops while idle
    reg_wr(3, (1 << 2) | 3); mval[1][3] = 0; mptr[1] = 3;
    reg_wr(3, (3 << 2) | 0); mval[3][0] = 0; mptr[3] = 0;
    reg_rd(1, d); chk(d == 0, "R9", d, 0, "no error on idle drop");
    turn_on();
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) look(s, mtag[s][w], "R9");
    fill(1, 40, "R9"); fill(1, 41, "R9"); fill(1, 42, "R9");
    fill(3, 50, "R9"); fill(3, 51, "R9");
    // R3: disable without lookup in flight
    reg_wr(0, 0);
    reg_rd(1, d); chk(d[0] == 1, "R3", d[0], 1, "state one cycle after idle disable");
    reg_rd(1, d); chk(d[0] == 0, "R3", d[0], 0, "state two cycles after idle disable");
    m_on = 0;
    look(1, 42, "R5");
    turn_on();
    // R8: wipe
    reg_wr(2, 1); model_wipe();
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < 6; k++) look(s, s * 8 + k + 1, "R8");
    for (int k = 0; k < 5; k++) fill(2, 20 + k, "R8");
    look(2, 24, "R8"); look(2, 20, "R8");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule